// File: doc/BRIEF.md
# Window Clip-Rectangle Pixel Filter

This block decides, for each incoming pixel, whether it survives the window clip-rectangle test. Up to four axis-aligned rectangles are configured, each with inclusive minimum and maximum corners. A configurable count selects how many of them take part. A mode flag chooses between two behaviours. In exclude mode, pixels lying in any active rectangle are removed. In include mode, only pixels inside at least one active rectangle are kept.

Internally the block forms a 4-bit membership code, in which bit i means "inside rectangle i". From the count and the mode it derives a 16-bit rule word. It then keeps the pixel when the rule bit selected by the code is 1. The verdict appears together with a valid flag one clock after the pixel is presented. The configuration is treated as quasi-static; it is sampled in the same cycle as the pixel.

Top module: `clip_rect_filter`

## Requirements
- R1: During and right after reset, out_valid is 0 and out_keep is 0.
- R2: out_valid equals the previous cycle's pix_valid, and out_keep reflects the pixel presented in that previous cycle (one-cycle latency).
- R3: Rectangle containment is inclusive on all four edges: a pixel is inside rectangle i when x_min <= x <= x_max and y_min <= y <= y_max.
- R4: A rectangle whose x_min > x_max or y_min > y_max contains no pixel.
- R5: With rect_count = 0 the rule word is 0xFFFF and every valid pixel is kept.
- R6: In exclude mode (include_mode = 0), the rule word for n = 1, 2, 3, 4 is 0x5555, 0x1111, 0x0101 and 0x0001. Only pixels whose code bits 0..n-1 are all zero are kept.
- R7: In include mode (include_mode = 1), the rule word is the bitwise inverse of the exclude rule for the same n. A pixel is kept when it lies in at least one active rectangle.
- R8: Rectangles with index >= rect_count have no effect. Their code bits are forced to 0.
- R9: The pixel is kept exactly when bit[code] of the rule word is 1, where code bit i is the membership in rectangle i.
- R10: rect_count values above 4 are treated as 4.
- R11: When pix_valid is 0, out_keep is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_x | input | 15 | Pixel X coordinate |
| pix_y | input | 15 | Pixel Y coordinate |
| rect_xmin | input | 60 | Four packed 15-bit left edges, rectangle i at bits [15i+14:15i] |
| rect_ymin | input | 60 | Four packed 15-bit top edges |
| rect_xmax | input | 60 | Four packed 15-bit right edges |
| rect_ymax | input | 60 | Four packed 15-bit bottom edges |
| rect_count | input | 3 | Number of active rectangles, 0 to 4 |
| include_mode | input | 1 | 1 = keep inside, 0 = keep outside |
| out_valid | output | 1 | Registered pixel qualifier |
| out_keep | output | 1 | Registered keep verdict |

## Verification
The bench places pixels exactly on every rectangle edge and one step outside it. A design that used exclusive bounds on any side would flip those verdicts. It also configures inverted rectangles, where a signed or swapped comparison would wrongly report containment. Inactive rectangles are set to cover the whole screen, so a filter that failed to mask indices at or above the count would reject or accept the wrong pixels. Every count and mode pair, including count 0 and out-of-range counts, is swept against a bench model of the rule word. An off-by-one in the rule pattern would therefore show up as a mismatch on random pixels.

// File: rtl/clip_rect_pkg.sv
package clip_rect_pkg;
    localparam int COORD_W  = 15;
    localparam int NUM_RECT = 4;
    localparam int CODE_W   = NUM_RECT;
    localparam int RULE_W   = 1 << NUM_RECT;
    localparam int CNT_W    = $clog2(NUM_RECT + 1);

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [RULE_W-1:0]  rule_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef struct packed {
        logic valid;
        logic keep;
    } out_state_t;
endpackage

// File: rtl/rect_hit.sv
module rect_hit
    import clip_rect_pkg::*;
(
    input  coord_t px,
    input  coord_t py,
    input  coord_t xmin,
    input  coord_t ymin,
    input  coord_t xmax,
    input  coord_t ymax,
    output logic   hit
);
    logic in_x;
    logic in_y;

    always_comb begin
        in_x = (px >= xmin) && (px <= xmax);
        in_y = (py >= ymin) && (py <= ymax);
        hit  = in_x && in_y;
    end
endmodule

// File: rtl/clip_rule_gen.sv
module clip_rule_gen
    import clip_rect_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic             include_mode,
    output rule_t            rule,
    output code_t            active_mask
);
    logic [CNT_W-1:0] n_eff;
    rule_t            excl;

    always_comb begin
        n_eff = (count > CNT_W'(NUM_RECT)) ? CNT_W'(NUM_RECT) : count;
        for (int i = 0; i < NUM_RECT; i++) begin
            active_mask[i] = (CNT_W'(i) < n_eff);
        end
        for (int c = 0; c < RULE_W; c++) begin
            excl[c] = ((code_t'(c) & active_mask) == '0);
        end
        if (n_eff == '0) begin
            rule = '1;
        end else if (include_mode) begin
            rule = ~excl;
        end else begin
            rule = excl;
        end
    end
endmodule

// File: rtl/clip_rect_filter.sv
module clip_rect_filter
    import clip_rect_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pix_valid,
    input  logic [COORD_W-1:0]          pix_x,
    input  logic [COORD_W-1:0]          pix_y,
    input  logic [NUM_RECT*COORD_W-1:0] rect_xmin,
    input  logic [NUM_RECT*COORD_W-1:0] rect_ymin,
    input  logic [NUM_RECT*COORD_W-1:0] rect_xmax,
    input  logic [NUM_RECT*COORD_W-1:0] rect_ymax,
    input  logic [CNT_W-1:0]            rect_count,
    input  logic                        include_mode,
    output logic                        out_valid,
    output logic                        out_keep
);
    code_t      raw_hit;
    code_t      active_mask;
    code_t      code;
    rule_t      rule;
    out_state_t st_d;
    out_state_t st_q;

    for (genvar g = 0; g < NUM_RECT; g++) begin : g_rect
        rect_hit u_hit (
            .px   (pix_x),
            .py   (pix_y),
            .xmin (rect_xmin[g*COORD_W +: COORD_W]),
            .ymin (rect_ymin[g*COORD_W +: COORD_W]),
            .xmax (rect_xmax[g*COORD_W +: COORD_W]),
            .ymax (rect_ymax[g*COORD_W +: COORD_W]),
            .hit  (raw_hit[g])
        );
    end

    clip_rule_gen u_rule (
        .count        (rect_count),
        .include_mode (include_mode),
        .rule         (rule),
        .active_mask  (active_mask)
    );

    always_comb begin
        code       = raw_hit & active_mask;
        st_d.valid = pix_valid;
        st_d.keep  = pix_valid & rule[code];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_keep  = st_q.keep;

    AST_KEEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_keep |-> out_valid); // R11
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(pix_valid)); // R2
    AST_NO_RECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && rect_count == '0) |=> out_keep); // R5
    AST_MASKED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rect_count == '0 |-> code == '0); // R8
    AST_INCL_OUTSIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && include_mode && rect_count != '0 && code == '0) |=> !out_keep); // R7
endmodule

// File: tb/clip_rect_filter_bench.sv
module clip_rect_filter_bench;
    import clip_rect_pkg::*;

    logic clk = 0;
    logic rst_n = 0;
    logic pix_valid = 0;
    logic [COORD_W-1:0] pix_x = 0, pix_y = 0;
    logic [NUM_RECT*COORD_W-1:0] rect_xmin = 0, rect_ymin = 0, rect_xmax = 0, rect_ymax = 0;
    logic [CNT_W-1:0] rect_count = 0;
    logic include_mode = 0;
    logic out_valid, out_keep;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clip_rect_filter u_clip_rect_filter (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .rect_xmin(rect_xmin), .rect_ymin(rect_ymin), .rect_xmax(rect_xmax),
        .rect_ymax(rect_ymax), .rect_count(rect_count), .include_mode(include_mode),
        .out_valid(out_valid), .out_keep(out_keep)
    );

    function automatic logic [15:0] model_rule(int n, bit inc);
        logic [15:0] r;
        int m;
        m = (n > 4) ? 4 : n;
        if (m == 0) return 16'hFFFF;
        case (m)
            1: r = 16'h5555;
            2: r = 16'h1111;
            3: r = 16'h0101;
            default: r = 16'h0001;
        endcase
        return inc ? ~r : r;
    endfunction

    function automatic bit model_keep(bit v);
        int code;
        int m;
        if (!v) return 0;
        m = (rect_count > 4) ? 4 : int'(rect_count);
        code = 0;
        for (int i = 0; i < m; i++) begin
            if (pix_x >= rect_xmin[i*15 +: 15] && pix_x <= rect_xmax[i*15 +: 15] &&
                pix_y >= rect_ymin[i*15 +: 15] && pix_y <= rect_ymax[i*15 +: 15])
                code |= (1 << i);
        end
        return model_rule(int'(rect_count), include_mode)[code];
    endfunction

    task automatic chk(string req, bit act, bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic set_rect(int i, int x0, int y0, int x1, int y1);
        rect_xmin[i*15 +: 15] = 15'(x0);
        rect_ymin[i*15 +: 15] = 15'(y0);
        rect_xmax[i*15 +: 15] = 15'(x1);
        rect_ymax[i*15 +: 15] = 15'(y1);
    endtask

    // drive on negedge, sample on next negedge (one register)
    task automatic pix(string req, bit v, int x, int y);
        bit ek;
        @(negedge clk);
        pix_valid = v;
        pix_x = 15'(x);
        pix_y = 15'(y);
        ek = model_keep(v);
        @(negedge clk);
        chk(req, out_valid, v);
        chk(req, out_keep, ek);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1", out_valid, 0);
        chk("R1", out_keep, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", out_valid, 0);

        // R5: no rectangles -> all pass
        rect_count = 0;
        pix("R5", 1, 100, 200);
        pix("R11", 0, 100, 200);

        // R3 inclusive edges, exclude mode with one rect
        set_rect(0, 10, 20, 30, 40);
        rect_count = 1;
        include_mode = 0;
        pix("R3", 1, 10, 20);
        pix("R3", 1, 30, 40);
        pix("R3", 1, 9, 25);
        pix("R3", 1, 31, 25);
        pix("R3", 1, 15, 19);
        pix("R3", 1, 15, 41);
        include_mode = 1;
        pix("R7", 1, 10, 40);
        pix("R7", 1, 31, 40);

        // R4 inverted rectangle
        set_rect(0, 50, 50, 40, 60);
        pix("R4", 1, 45, 55);
        pix("R4", 1, 50, 55);
        include_mode = 0;
        pix("R4", 1, 45, 55);

        // R8 inactive full-screen rectangles
        set_rect(0, 0, 0, 5, 5);
        set_rect(1, 0, 0, 32767, 32767);
        set_rect(2, 0, 0, 32767, 32767);
        set_rect(3, 0, 0, 32767, 32767);
        rect_count = 1;
        include_mode = 0;
        pix("R8", 1, 100, 100);
        include_mode = 1;
        pix("R8", 1, 100, 100);

        // R10 out-of-range counts
        rect_count = 7;
        include_mode = 0;
        pix("R10", 1, 100, 100);

        // R6/R7/R9 sweeps with random rectangles and pixels
        for (int it = 0; it < 3000; it++) begin
            for (int r = 0; r < 4; r++) begin
                int a, b, c, d;
                a = $urandom_range(0, 200); b = $urandom_range(0, 200);
                c = $urandom_range(0, 200); d = $urandom_range(0, 200);
                set_rect(r, a, b, c, d);
            end
            rect_count = 3'($urandom_range(0, 7));
            include_mode = 1'($urandom_range(0, 1));
            if (include_mode) pix("R7", 1'($urandom_range(0, 7) != 0), $urandom_range(0, 210), $urandom_range(0, 210));
            else pix("R6_R9", 1'($urandom_range(0, 7) != 0), $urandom_range(0, 210), $urandom_range(0, 210));
        end

        // R2 back-to-back stream check
        set_rect(0, 0, 0, 10, 10);
        rect_count = 1;
        include_mode = 1;
        @(negedge clk); pix_valid = 1; pix_x = 5; pix_y = 5;
        @(negedge clk); chk("R2", out_keep, 1); pix_x = 20;
        @(negedge clk); chk("R2", out_keep, 0); pix_valid = 0;
        @(negedge clk); chk("R2", out_valid, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule